// File: doc/BRIEF.md
# PCM Fade and Mute Level Controller

This block scales a stream of 16-bit stereo PCM samples by a gain taken from a small level counter. Short 4-bit commands move the counter: three of them jump it to a preset (silence, a fixed -12 dB cut, or unity), and two nudge it one step up or down. A host that wants a smooth fade issues a series of step commands. It does not write a gain value directly. The gain follows an exponential curve, so each step changes the volume by roughly the same number of decibels.

The level is held in a three-state machine. `ST_MUTE` covers level 0. `ST_RAMP` covers any level between the two limits. `ST_FULL` covers the top level. The mute command moves the machine to `ST_MUTE` from any state, the full-scale command moves it to `ST_FULL`, and the attenuate command moves it to `ST_RAMP`. A step up from `ST_MUTE` enters `ST_RAMP`. A step up from `ST_RAMP` either stays in `ST_RAMP` or reaches `ST_FULL`, and a step up in `ST_FULL` holds. A step down mirrors this: it runs `ST_FULL` to `ST_RAMP`, `ST_RAMP` to `ST_RAMP` or to `ST_MUTE`, and holds in `ST_MUTE`.

Each valid input sample pair is multiplied by the current gain and rounded toward zero. The result appears on the output one clock later.

Top module: `pcm_fade_ctl`

## Requirements
- R1: After reset the level is 0 (muted), `out_vld` is 0 and both output samples are 0.
- R2: A command whose low three bits are 000 sets the level to 0 (mute). Bit 3 of the code is ignored for every command.
- R3: Low bits 001 set the level to the top level 32, where the gain is exactly 1.0 and each output sample equals its input sample.
- R4: Low bits 010 or 011 set the level to 16, giving a gain of exactly 0.25 (-12 dB).
- R5: Low bits 101 raise the level by one, and the level saturates at 32.
- R6: Low bits 100 lower the level by one, and the level saturates at 0 without wrapping.
- R7: Low bits 110 or 111 leave the level unchanged. Any code presented while `cmd_vld` is low also leaves the level unchanged.
- R8: For a level k > 0, let j = 32 - k. The gain is (16 - (j mod 8)) * 2^(11 - floor(j/8)) / 32768. Level 0 has a gain of 0. The gain rises strictly with k.
- R9: Each channel's output is the two's-complement product of the sample and the gain, truncated toward zero. The output is exactly 0 while muted and is never larger in magnitude than the input.
- R10: `out_vld` follows `in_vld` with a latency of one cycle. A sample uses the level held before any command accepted on the same edge, and a command takes effect for samples presented on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_vld | input | 1 | Command strobe |
| cmd_code | input | 4 | Command code; bit 3 is ignored |
| in_vld | input | 1 | Input sample pair valid |
| in_left | input | 16 | Left input sample, two's complement |
| in_right | input | 16 | Right input sample, two's complement |
| out_vld | output | 1 | Output sample pair valid |
| out_left | output | 16 | Scaled left sample |
| out_right | output | 16 | Scaled right sample |

## Verification
The level counter is not visible at the ports, so any fault in the counter shows up in the scaled output of the very next sample. A wrong level gives a ratio between output and input that does not match the expected gain for that level. A counter that wraps instead of saturating turns silence into full volume, or full volume into silence, after a single step. The bench therefore probes every level with full-scale, near-zero and odd-valued samples of both signs. This exposes errors in the gain curve, in the rounding of negative products and in the saturation at both limits within one sample of the faulty command.

// File: rtl/fade_pkg.sv
package fade_pkg;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_MUTE,
        OP_FULL,
        OP_ATTEN,
        OP_DOWN,
        OP_UP
    } fade_op_e;

    typedef enum logic [1:0] {
        ST_MUTE,
        ST_RAMP,
        ST_FULL
    } lvl_state_e;

    // Bit 3 of the command code carries no meaning.
    function automatic fade_op_e decode_op(input logic [3:0] code);
        fade_op_e op;
        casez (code[2:0])
            3'b000:  op = OP_MUTE;
            3'b001:  op = OP_FULL;
            3'b01?:  op = OP_ATTEN;
            3'b100:  op = OP_DOWN;
            3'b101:  op = OP_UP;
            default: op = OP_NONE;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/fade_level_fsm.sv
module fade_level_fsm
    import fade_pkg::*;
#(
    parameter int LVL_MAX = 32,
    parameter int ATT_LVL = 16,
    parameter int LVL_W   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_vld,
    input  logic [3:0]       cmd_code,
    output logic [LVL_W-1:0] lvl,
    output lvl_state_e       state
);

    localparam logic [LVL_W-1:0] TOP = LVL_W'(LVL_MAX);
    localparam logic [LVL_W-1:0] ATT = LVL_W'(ATT_LVL);

    fade_op_e          op;
    logic [LVL_W-1:0]  lvl_nxt;
    lvl_state_e        st_nxt;

    always_comb begin
        op      = cmd_vld ? decode_op(cmd_code) : OP_NONE;
        lvl_nxt = lvl;
        st_nxt  = state;
        unique case (op)
            OP_MUTE: begin
                lvl_nxt = '0;
                st_nxt  = ST_MUTE;
            end
            OP_FULL: begin
                lvl_nxt = TOP;
                st_nxt  = ST_FULL;
            end
            OP_ATTEN: begin
                lvl_nxt = ATT;
                st_nxt  = ST_RAMP;
            end
            OP_UP: begin
                unique case (state)
                    ST_FULL: lvl_nxt = lvl;
                    default: begin
                        lvl_nxt = lvl + 1'b1;
                        st_nxt  = (lvl_nxt == TOP) ? ST_FULL : ST_RAMP;
                    end
                endcase
            end
            OP_DOWN: begin
                unique case (state)
                    ST_MUTE: lvl_nxt = lvl;
                    default: begin
                        lvl_nxt = lvl - 1'b1;
                        st_nxt  = (lvl_nxt == '0) ? ST_MUTE : ST_RAMP;
                    end
                endcase
            end
            default: begin
                lvl_nxt = lvl;
                st_nxt  = state;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_MUTE;
            lvl   <= '0;
        end else begin
            state <= st_nxt;
            lvl   <= lvl_nxt;
        end
    end

    p_state_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_MUTE) == (lvl == '0)) && ((state == ST_FULL) == (lvl == TOP)));

    p_up_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && cmd_code[2:0] == 3'b101 && lvl < TOP) |=> lvl == $past(lvl) + 1'b1);

    p_up_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && cmd_code[2:0] == 3'b101 && lvl == TOP) |=> lvl == TOP);

    p_down_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && cmd_code[2:0] == 3'b100 && lvl != '0) |=> lvl == $past(lvl) - 1'b1);

    p_down_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && cmd_code[2:0] == 3'b100 && lvl == '0) |=> lvl == '0);

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_vld || cmd_code[2:1] == 2'b11) |=> $stable(lvl));

    p_level_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lvl <= TOP);

endmodule

// File: rtl/fade_gain_lut.sv
module fade_gain_lut #(
    parameter int LVL_MAX   = 32,
    parameter int LVL_W     = 6,
    parameter int MANT_W    = 3,
    parameter int GAIN_FRAC = 15
) (
    input  logic [LVL_W-1:0]   lvl,
    output logic [GAIN_FRAC:0] gain
);

    localparam int GAIN_W   = GAIN_FRAC + 1;
    localparam int MANT_ONE = 1 << (MANT_W + 1);
    localparam int TOP_SH   = GAIN_FRAC - MANT_W - 1;

    logic [LVL_W-1:0]  atten;
    logic [LVL_W-1:0]  octave;
    logic [GAIN_W-1:0] mant;

    always_comb begin
        atten  = LVL_W'(LVL_MAX) - lvl;
        octave = atten >> MANT_W;
        mant   = GAIN_W'(MANT_ONE) - GAIN_W'(atten[MANT_W-1:0]);
        if (lvl == '0) begin
            gain = '0;
        end else begin
            gain = (mant << TOP_SH) >> octave;
        end
    end

endmodule

// File: rtl/fade_scaler.sv
module fade_scaler #(
    parameter int DATA_W    = 16,
    parameter int GAIN_FRAC = 15
) (
    input  logic signed [DATA_W-1:0] sample,
    input  logic        [GAIN_FRAC:0] gain,
    output logic signed [DATA_W-1:0] scaled
);

    localparam int GAIN_W = GAIN_FRAC + 1;
    localparam int PW     = DATA_W + GAIN_W + 1;

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] biased;

    always_comb begin
        prod   = PW'(sample) * $signed(PW'(gain));
        biased = prod + (prod[PW-1] ? PW'((1 << GAIN_FRAC) - 1) : PW'(0));
        scaled = DATA_W'(biased >>> GAIN_FRAC);
    end

endmodule

// File: rtl/pcm_fade_ctl.sv
module pcm_fade_ctl
    import fade_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int MANT_W  = 3,
    parameter int OCTAVES = 4,
    parameter int ATT_OCT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_vld,
    input  logic [3:0]        cmd_code,
    input  logic              in_vld,
    input  logic [DATA_W-1:0] in_left,
    input  logic [DATA_W-1:0] in_right,
    output logic              out_vld,
    output logic [DATA_W-1:0] out_left,
    output logic [DATA_W-1:0] out_right
);

    localparam int LVL_MAX   = OCTAVES << MANT_W;
    localparam int ATT_LVL   = LVL_MAX - (ATT_OCT << MANT_W);
    localparam int LVL_W     = $clog2(LVL_MAX + 1);
    localparam int GAIN_FRAC = DATA_W - 1;
    localparam int NCH       = 2;

    logic [LVL_W-1:0]            lvl;
    lvl_state_e                  state;
    logic [GAIN_FRAC:0]          gain;
    logic [NCH-1:0][DATA_W-1:0]  smp_in;
    logic [NCH-1:0][DATA_W-1:0]  smp_sc;

    fade_level_fsm #(
        .LVL_MAX (LVL_MAX),
        .ATT_LVL (ATT_LVL),
        .LVL_W   (LVL_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_vld  (cmd_vld),
        .cmd_code (cmd_code),
        .lvl      (lvl),
        .state    (state)
    );

    fade_gain_lut #(
        .LVL_MAX   (LVL_MAX),
        .LVL_W     (LVL_W),
        .MANT_W    (MANT_W),
        .GAIN_FRAC (GAIN_FRAC)
    ) u_lut (
        .lvl  (lvl),
        .gain (gain)
    );

    assign smp_in[0] = in_left;
    assign smp_in[1] = in_right;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        fade_scaler #(
            .DATA_W    (DATA_W),
            .GAIN_FRAC (GAIN_FRAC)
        ) u_scl (
            .sample (smp_in[ch]),
            .gain   (gain),
            .scaled (smp_sc[ch])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld   <= 1'b0;
            out_left  <= '0;
            out_right <= '0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                out_left  <= smp_sc[0];
                out_right <= smp_sc[1];
            end
        end
    end

    function automatic logic [DATA_W:0] mag(input logic [DATA_W-1:0] v);
        logic signed [DATA_W:0] w;
        w = $signed({v[DATA_W-1], v});
        return (w < 0) ? (DATA_W+1)'(-w) : (DATA_W+1)'(w);
    endfunction

    p_mute_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && state == ST_MUTE) |=> (out_left == '0 && out_right == '0));

    p_unity_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && state == ST_FULL) |=>
            (out_left == $past(in_left) && out_right == $past(in_right)));

    p_no_growth_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> (mag(out_left) <= mag($past(in_left)) &&
                    mag(out_right) <= mag($past(in_right))));

    p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);

    p_idle_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);

endmodule

// File: tb/tb_pcm_fade_ctl.sv
module tb_pcm_fade_ctl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_vld = 1'b0;
    logic [3:0]  cmd_code = 4'd0;
    logic        in_vld = 1'b0;
    logic [15:0] in_left = '0;
    logic [15:0] in_right = '0;
    logic        out_vld;
    logic [15:0] out_left;
    logic [15:0] out_right;

    int n_chk = 0;
    int n_bad = 0;
    int lvl_m = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pcm_fade_ctl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_vld   (cmd_vld),
        .cmd_code  (cmd_code),
        .in_vld    (in_vld),
        .in_left   (in_left),
        .in_right  (in_right),
        .out_vld   (out_vld),
        .out_left  (out_left),
        .out_right (out_right)
    );

    int smp [8] = '{32767, -32768, -1, 1, 12345, -12345, 0, -20001};

    // Gain curve taken from R8, expressed in units of 1/32768
    function automatic int mgain(input int k);
        int j;
        if (k <= 0) return 0;
        j = 32 - k;
        return (16 - (j % 8)) * (2048 >> (j / 8));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cmd(input logic [3:0] code);
        cmd_code = code;
        cmd_vld  = 1'b1;
        @(negedge clk);
        cmd_vld  = 1'b0;
    endtask

    // Presents one pair, then checks the registered result one cycle later
    task automatic probe(input int l, input int r, input int g, input string req);
        int el, er;
        in_left  = 16'(l);
        in_right = 16'(r);
        in_vld   = 1'b1;
        @(negedge clk);
        in_vld   = 1'b0;
        el = (l * g) / 32768;
        er = (r * g) / 32768;
        chk(out_vld == 1'b1, {req, " R10 out_vld"}, int'(out_vld), 1);
        chk(int'($signed(out_left)) == el, {req, " left"}, int'($signed(out_left)), el);
        chk(int'($signed(out_right)) == er, {req, " right"}, int'($signed(out_right)), er);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(out_vld == 1'b0, "R1 out_vld", int'(out_vld), 0);
        chk(out_left == 16'd0 && out_right == 16'd0, "R1 outputs", int'(out_left), 0);
        probe(1000, -1000, 0, "R1 muted after reset");

        // R5 R8 R9 sweep up through every level, one step past the top
        lvl_m = 0;
        for (int k = 0; k <= 33; k++) begin
            for (int i = 0; i < 8; i++)
                probe(smp[i], smp[7 - i], mgain(lvl_m), "R8 R9 sweep up");
            cmd(4'b0101);
            lvl_m = (lvl_m < 32) ? lvl_m + 1 : 32;
        end
        probe(-32768, 32767, 32768, "R5 saturated at top");

        // R6 sweep down past level 0
        for (int k = 0; k <= 33; k++) begin
            cmd(4'b1100);
            lvl_m = (lvl_m > 0) ? lvl_m - 1 : 0;
            probe(32767, -32767, mgain(lvl_m), "R6 sweep down");
        end
        probe(-5, 5, 0, "R6 saturated at mute");

        // R3 full scale, bit 3 set
        cmd(4'b1001);
        probe(-32768, 32767, 32768, "R3 full scale");
        probe(-3, 3, 32768, "R3 small");

        // R4 attenuate, both encodings
        cmd(4'b0010);
        probe(32767, -32768, 8192, "R4 atten 010");
        probe(-7, 7, 8192, "R4 atten rounding");
        cmd(4'b0001);
        cmd(4'b1011);
        probe(-32767, 20000, 8192, "R4 atten 1011");

        // R7 reserved codes and idle strobe
        cmd(4'b0110);
        probe(30000, -30001, 8192, "R7 code 0110");
        cmd(4'b1111);
        probe(30000, -30001, 8192, "R7 code 1111");
        cmd_code = 4'b0001;
        @(negedge clk);
        probe(30000, -30001, 8192, "R7 cmd_vld low");

        // R2 mute with bit 3 set
        cmd(4'b1000);
        probe(32767, -32768, 0, "R2 mute");

        // R10 command and sample on the same edge
        cmd(4'b0001);
        in_left  = 16'(-1234);
        in_right = 16'(4321);
        in_vld   = 1'b1;
        cmd_code = 4'b0000;
        cmd_vld  = 1'b1;
        @(negedge clk);
        in_vld  = 1'b0;
        cmd_vld = 1'b0;
        chk(int'($signed(out_left)) == -1234, "R10 old gain left", int'($signed(out_left)), -1234);
        chk(int'($signed(out_right)) == 4321, "R10 old gain right", int'($signed(out_right)), 4321);
        @(negedge clk);
        chk(out_vld == 1'b0, "R10 out_vld drops", int'(out_vld), 0);
        probe(-1234, 4321, 0, "R10 new gain");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule